// File: doc/BRIEF.md
# Polled Keyboard and Display Port

This block connects a byte-wide keyboard source and a byte-wide display sink to a processor bus as four small registers in the I/O address space: a keyboard data register, a display data register, a status register and a control register. The processor finds out whether it can move a byte by reading the status register over and over. It then reads the keyboard data register, or writes the display data register.

A register is selected only while the I/O-select qualifier is high and a read or write strobe is active. The decoder then compares the low `DEC_W` bits of the address and ignores the upper bits. A keyboard byte is taken whenever `kbd_valid` pulses. A write to the display data register gives one load pulse to the display, and the display reports back that it can accept the next byte. The interrupt request and enable bits are stored and can be read back, but they have no effect.

Top module: `kbd_disp_port`

## Requirements
- R1: A register access takes place only when `bus_iosel` is high and `bus_rd` or `bus_wr` is high. The register is chosen by the low `DEC_W` (default 4) address bits: offset 0 keyboard data, 1 display data, 2 status, 3 control. Upper address bits are ignored. With `bus_iosel` low, no register changes and `bus_rdata` is 0.
- R2: A `kbd_valid` pulse stores `kbd_byte` and sets status bit 0 (input ready) in the next cycle. A read of offset 0 returns the stored byte.
- R3: A read of offset 0 clears input ready in the next cycle. If `kbd_valid` arrives in the same cycle, input ready stays 1 and the new byte is stored.
- R4: A write to offset 1 while status bit 1 (output ready) is 1 has three effects in the next cycle. `disp_byte` takes the written byte, `disp_load` is high for exactly one cycle, and output ready reads 0.
- R5: Output ready becomes 1 again one cycle after the first cycle in which `disp_ready` is high once the load pulse is over. A write to offset 1 while output ready is 0 is ignored.
- R6: Status bit 2 (overrun) is set when `kbd_valid` arrives while input ready is 1 and offset 0 is not read in that cycle. The new byte replaces the old one. Any status read clears overrun, unless a new overrun occurs in the same cycle.
- R7: Control (offset 3) stores all 8 written bits and reads them back. Status bits 5:4 are writable storage for request flags. Status bits 0 to 2 ignore writes, and status bits 7:6 and 3 read 0.
- R8: Offsets 4 to 15 read as 0, and writes to them change no register.
- R9: After reset, input ready and overrun are 0 and output ready is 1. Keyboard data, display data, control and the status storage bits are 0, and `disp_load` is 0.
- R10: `bus_rdata` is 0 in any cycle without a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_iosel | input | 1 | I/O access qualifier |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected register |
| kbd_byte | input | 8 | Keyboard byte |
| kbd_valid | input | 1 | One-cycle strobe for `kbd_byte` |
| disp_byte | output | 8 | Byte presented to the display |
| disp_load | output | 1 | One-cycle pulse telling the display to take `disp_byte` |
| disp_ready | input | 1 | Display can accept a byte |

## Verification
The handshake flags are exercised by keyboard bursts with and without reads in between. This separates a clean take from an overrun, and it also shows which of a same-cycle read and a new keyboard byte wins. Display writes are issued both while the display is idle and while it is still busy, with display latencies of 1 to 4 cycles, so an accepted write can be told apart from an ignored one. Reads and writes are sent to mapped offsets, to unmapped offsets, with random upper address bits and with the qualifier low. These cases separate correct low-bit decoding from decoding of the full address or decoding that ignores the qualifier.

// File: rtl/kdp_pkg.sv
// Shared constants for the keyboard/display port.
// Assumes DEC_W >= 2, so that the four register offsets fit in the decoded bits.
package kdp_pkg;
    localparam int NREG     = 4;
    localparam int OFF_KIN  = 0;   // keyboard data
    localparam int OFF_DOUT = 1;   // display data
    localparam int OFF_STAT = 2;   // status
    localparam int OFF_CTRL = 3;   // control

    localparam int ST_IN    = 0;   // input ready
    localparam int ST_OUT   = 1;   // output ready
    localparam int ST_OVR   = 2;   // overrun
    localparam int ST_SW_LO = 4;   // writable request flags
    localparam int ST_SW_W  = 2;
endpackage

// File: rtl/kdp_decode.sv
// Address decoder: one read select and one write select per register.
// A select is active only while the I/O qualifier is high. Only the low DEC_W
// address bits are compared, and DEC_W must be smaller than ADDR_W.
module kdp_decode #(
    parameter int ADDR_W = 16,
    parameter int DEC_W  = 4,
    parameter int NSEL   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iosel,
    input  logic              rd,
    input  logic              wr,
    output logic [NSEL-1:0]   rd_sel,
    output logic [NSEL-1:0]   wr_sel
);
    logic [DEC_W-1:0] low_addr;

    // low_addr: the only address bits that take part in decoding
    assign low_addr = addr[DEC_W-1:0];

    genvar i;
    generate
        for (i = 0; i < NSEL; i++) begin : g_sel
            // compare the offset of register i
            assign rd_sel[i] = iosel & rd & (low_addr == DEC_W'(i));
            assign wr_sel[i] = iosel & wr & (low_addr == DEC_W'(i));
        end
    endgenerate

    assert_onehot_rd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));
    assert_onehot_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
    assert_no_sel_without_io_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !iosel |-> (rd_sel == '0 && wr_sel == '0));
    // a change in the upper address bits alone leaves the selects unchanged
    assert_upper_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(low_addr) && $stable(iosel) && $stable(rd) && $stable(wr)
         && !$stable(addr[ADDR_W-1:DEC_W])) |-> $stable(rd_sel));
endmodule

// File: rtl/kdp_kbd_in.sv
// Keyboard input buffer with the input-ready and overrun flags.
// Assumes kbd_valid is a one-cycle strobe. take is a decoded read of the
// keyboard data register, and st_read is a decoded read of status.
module kdp_kbd_in #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] kbd_byte,
    input  logic              kbd_valid,
    input  logic              take,
    input  logic              st_read,
    output logic [DATA_W-1:0] data_q,
    output logic              in_rdy,
    output logic              ovr
);
    logic ovr_evt;

    // an overrun is a new byte arriving while an unread byte waits and is not taken now
    assign ovr_evt = kbd_valid & in_rdy & ~take;

    // buffer, ready flag and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            in_rdy <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (kbd_valid) begin
                data_q <= kbd_byte;
                in_rdy <= 1'b1;
            end else if (take) begin
                in_rdy <= 1'b0;
            end
            if (ovr_evt) begin
                ovr <= 1'b1;
            end else if (st_read) begin
                ovr <= 1'b0;
            end
        end
    end

    assert_kbd_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_valid |=> (in_rdy && data_q == $past(kbd_byte)));
    assert_take_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !kbd_valid) |=> !in_rdy);
    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_valid && in_rdy && !take) |=> ovr);
    assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_read && !(kbd_valid && in_rdy && !take)) |=> !ovr);
endmodule

// File: rtl/kdp_disp_out.sv
// Display output register with the output-ready handshake.
// wr_req is a decoded write of the display data register. It is accepted only
// while out_rdy is 1. disp_ready is ignored in the cycle of the load pulse.
module kdp_disp_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              disp_ready,
    output logic [DATA_W-1:0] dout_q,
    output logic              out_rdy,
    output logic              disp_load
);
    // accept a write, pulse the load, wait for the display to become ready again
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q    <= '0;
            out_rdy   <= 1'b1;
            disp_load <= 1'b0;
        end else begin
            disp_load <= 1'b0;
            if (wr_req && out_rdy) begin
                dout_q    <= wdata;
                out_rdy   <= 1'b0;
                disp_load <= 1'b1;
            end else if (!out_rdy && !disp_load && disp_ready) begin
                out_rdy <= 1'b1;
            end
        end
    end

    assert_write_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && out_rdy) |=> (!out_rdy && disp_load && dout_q == $past(wdata)));
    assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_load |=> !disp_load);
    assert_busy_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !out_rdy) |=> ($stable(dout_q) && !disp_load));
    assert_ready_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy && !disp_load && disp_ready) |=> out_rdy);
endmodule

// File: rtl/kbd_disp_port.sv
// Polled keyboard/display port on a simple synchronous I/O bus.
// Holds the control register and the writable status bits, and builds the
// combinational read data. Assumes at most one of rd/wr per access matters per register.
module kbd_disp_port #(
    parameter int ADDR_W = 16,
    parameter int DEC_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_iosel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] kbd_byte,
    input  logic              kbd_valid,
    output logic [DATA_W-1:0] disp_byte,
    output logic              disp_load,
    input  logic              disp_ready
);
    import kdp_pkg::*;

    logic [NREG-1:0]    rd_sel;
    logic [NREG-1:0]    wr_sel;
    logic [DATA_W-1:0]  kin_q;
    logic               in_rdy;
    logic               ovr;
    logic               out_rdy;
    logic [DATA_W-1:0]  ctrl_q;
    logic [ST_SW_W-1:0] st_sw_q;
    logic [DATA_W-1:0]  status_w;

    kdp_decode #(.ADDR_W(ADDR_W), .DEC_W(DEC_W), .NSEL(NREG)) i_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .iosel  (bus_iosel),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    kdp_kbd_in #(.DATA_W(DATA_W)) i_kin (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_byte  (kbd_byte),
        .kbd_valid (kbd_valid),
        .take      (rd_sel[OFF_KIN]),
        .st_read   (rd_sel[OFF_STAT]),
        .data_q    (kin_q),
        .in_rdy    (in_rdy),
        .ovr       (ovr)
    );

    kdp_disp_out #(.DATA_W(DATA_W)) i_dout (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_sel[OFF_DOUT]),
        .wdata      (bus_wdata),
        .disp_ready (disp_ready),
        .dout_q     (disp_byte),
        .out_rdy    (out_rdy),
        .disp_load  (disp_load)
    );

    // control storage and writable status flags; neither drives any other logic
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            st_sw_q <= '0;
        end else begin
            if (wr_sel[OFF_CTRL]) ctrl_q  <= bus_wdata;
            if (wr_sel[OFF_STAT]) st_sw_q <= bus_wdata[ST_SW_LO +: ST_SW_W];
        end
    end

    // assemble the status word from the flags
    always_comb begin
        status_w                       = '0;
        status_w[ST_IN]                = in_rdy;
        status_w[ST_OUT]               = out_rdy;
        status_w[ST_OVR]               = ovr;
        status_w[ST_SW_LO +: ST_SW_W]  = st_sw_q;
    end

    // read data multiplexer, zero when no register is selected for reading
    always_comb begin
        bus_rdata = '0;
        if (rd_sel[OFF_KIN])  bus_rdata = kin_q;
        if (rd_sel[OFF_DOUT]) bus_rdata = disp_byte;
        if (rd_sel[OFF_STAT]) bus_rdata = status_w;
        if (rd_sel[OFF_CTRL]) bus_rdata = ctrl_q;
    end

    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_iosel && bus_rd) |-> (bus_rdata == '0));
    assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_iosel |=> $stable(ctrl_q));
    assert_ctrl_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[OFF_CTRL] |=> (ctrl_q == $past(bus_wdata)));
    assert_unmapped_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_iosel && bus_wr && !bus_rd && bus_addr[DEC_W-1:0] >= DEC_W'(NREG))
        |=> ($stable(ctrl_q) && $stable(st_sw_q) && $stable(disp_byte)));
endmodule

// File: tb/test_kbd_disp_port.sv
`timescale 1ns/1ps
module test_kbd_disp_port;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_iosel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  kbd_byte = '0;
    logic        kbd_valid = 1'b0;
    logic [7:0]  disp_byte;
    logic        disp_load;
    logic        disp_ready = 1'b1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_in, m_dout, m_ctrl;
    logic [1:0] m_sw;
    logic       m_sin, m_sout, m_ovr, m_load;
    int         d_cnt = 0;

    always #HALF clk = ~clk;

    kbd_disp_port i_kbd_disp_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_iosel(bus_iosel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_byte(kbd_byte), .kbd_valid(kbd_valid), .disp_byte(disp_byte),
        .disp_load(disp_load), .disp_ready(disp_ready)
    );

    function automatic logic [7:0] exp_rdata(input logic io, input logic rd, input logic [3:0] off);
        if (!(io && rd)) return 8'h00;
        case (off)
            4'd0: return m_in;
            4'd1: return m_dout;
            4'd2: return {2'b00, m_sw, 1'b0, m_ovr, m_sout, m_sin};
            4'd3: return m_ctrl;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_in = '0; m_dout = '0; m_ctrl = '0; m_sw = '0;
        m_sin = 0; m_sout = 1; m_ovr = 0; m_load = 0;
    endfunction

    // one bus cycle: drive at the falling edge, check, advance the model
    task automatic step(input logic io, input logic rd, input logic wr, input logic [15:0] a,
                        input logic [7:0] wd, input logic kv, input logic [7:0] kb, input string tag);
        logic [3:0] off;
        logic rd_in, rd_st, ovr_set;
        @(negedge clk);
        if (disp_load) begin
            disp_ready = 1'b0;
            d_cnt = 1 + int'($urandom % 4);
        end else if (d_cnt > 0) begin
            d_cnt--;
            if (d_cnt == 0) disp_ready = 1'b1;
        end
        bus_iosel = io; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        kbd_valid = kv; kbd_byte = kb;
        #0.5;
        off = a[3:0];
        chk(tag, bus_rdata, exp_rdata(io, rd, off));
        chk("R4 load", {7'b0, disp_load}, {7'b0, m_load});
        if (m_load) chk("R4 byte", disp_byte, m_dout);
        rd_in   = io && rd && off == 4'd0;
        rd_st   = io && rd && off == 4'd2;
        ovr_set = kv && m_sin && !rd_in;
        m_ovr   = ovr_set ? 1'b1 : (rd_st ? 1'b0 : m_ovr);
        if (kv) begin m_in = kb; m_sin = 1'b1; end
        else if (rd_in) m_sin = 1'b0;
        if (io && wr && off == 4'd1 && m_sout) begin
            m_dout = wd; m_sout = 1'b0; m_load = 1'b1;
        end else begin
            if (!m_sout && !m_load && disp_ready) m_sout = 1'b1;
            m_load = 1'b0;
        end
        if (io && wr && off == 4'd3) m_ctrl = wd;
        if (io && wr && off == 4'd2) m_sw = wd[5:4];
    endtask

    task automatic rd_reg(input logic [15:0] a, input string tag);
        step(1, 1, 0, a, 8'h00, 0, 8'h00, tag);
    endtask
    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1, 0, 1, a, d, 0, 8'h00, tag);
    endtask
    task automatic key(input logic [7:0] b, input string tag);
        step(0, 0, 0, 16'h0, 8'h00, 1, b, tag);
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset values
        rd_reg(16'h0002, "R9 status");
        rd_reg(16'h0000, "R9 kbd data");
        rd_reg(16'h0001, "R9 disp data");
        rd_reg(16'h0003, "R9 control");
        step(0, 0, 0, 16'h0, 8'h0, 0, 8'h0, "R10 idle");

        // R2/R1 key arrives, status read with upper bits set, data read
        key(8'h41, "R2 key");
        rd_reg(16'hAB32, "R1 upper bits ignored");
        rd_reg(16'h0000, "R2 kbd data");
        rd_reg(16'h0002, "R3 ready cleared");

        // R6 overrun and its clearing
        key(8'h10, "R6 key a");
        key(8'h11, "R6 key b");
        rd_reg(16'h0002, "R6 overrun set");
        rd_reg(16'h0002, "R6 overrun cleared");

        // R3 read and new key in the same cycle
        step(1, 1, 0, 16'h0000, 8'h00, 1, 8'h22, "R3 read with key");
        rd_reg(16'h0002, "R3 ready kept");
        rd_reg(16'h0000, "R3 new byte");

        // R1 qualifier low, R7 storage
        step(0, 0, 1, 16'h0003, 8'hFF, 0, 8'h00, "R1 no iosel write");
        step(0, 1, 0, 16'h0003, 8'h00, 0, 8'h00, "R1 no iosel read");
        rd_reg(16'h0003, "R1 control unchanged");
        wr_reg(16'h0003, 8'hA5, "R7 control write");
        rd_reg(16'h0003, "R7 control read");
        wr_reg(16'h0002, 8'hFF, "R7 status write");
        rd_reg(16'h0002, "R7 status storage");

        // R8 unmapped offsets
        wr_reg(16'h0005, 8'h77, "R8 unmapped write");
        rd_reg(16'h0005, "R8 unmapped read");
        rd_reg(16'h000F, "R8 unmapped read top");
        rd_reg(16'h0003, "R8 control intact");

        // R4/R5 display transfer and busy write
        wr_reg(16'h0001, 8'h5A, "R4 display write");
        wr_reg(16'h0001, 8'h99, "R5 busy write");
        rd_reg(16'h0002, "R4 output busy");
        repeat (8) rd_reg(16'h0002, "R5 ready returns");
        rd_reg(16'h0001, "R5 busy write ignored");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic io, rd, wr, kv;
            logic [15:0] a;
            io = ($urandom % 8) != 0;
            rd = $urandom % 2;
            wr = !rd && ($urandom % 3 == 0);
            kv = ($urandom % 4) == 0;
            a  = {12'($urandom), 4'($urandom % 6)};
            step(io, rd, wr, a, 8'($urandom), kv, 8'($urandom), "R1-decode random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule